// File: doc/BRIEF.md
# Display Controller Boot Sequencer

This block brings an external display, touch and audio controller out of power-down after a system reset. It cycles the active-low power-down pin, sends four three-byte host commands separated by millisecond pauses, and polls the controller's identification register until the controller answers with its identity byte. It then programs the panel timing, backlight, GPIO and touch settings, loads a two-word display list, swaps that list in and only then turns on the pixel clock.

The block does not shift SPI bits. It hands each transaction to a separate SPI transaction engine through a request/acknowledge handshake. A transaction has a kind code, a 22-bit address and up to 32 bits of data, and the engine returns the read byte with its acknowledge. When the sequence completes, `done` rises. If the identity byte never appears within a parameterised number of polls, `err` rises and the sequence stops. Millisecond pauses come from a prescaler whose clocks-per-millisecond value is a parameter.

Top module: `dbs_boot_seq`

## Requirements
- R1: While `rst_n` is low, `pd_n` is 1 and `req`, `done` and `err` are 0.
- R2: After reset, `pd_n` goes low for 20 ms and then returns high. A 20 ms pause follows before the first request.
  - Each pause lasts between 20·CLKS_PER_MS and 20·CLKS_PER_MS+2 cycles.
  - `req` is never high while `pd_n` is low.
- R3: Four host commands then follow, in this order: wake 0x00, external oscillator 0x44, 48 MHz PLL 0x62, core reset 0x68.
  - Each uses kind 0, address 0 and the code in `wdata[7:0]`.
  - After the acknowledge of a command, the next request waits 20, 10 and 10 ms respectively. A wait of N ms lies between N·CLKS_PER_MS and N·CLKS_PER_MS+2 cycles.
  - No wait follows the core reset.
- R4: The identity register is register 0. Register k lives at REG_BASE+4k, with REG_BASE = 0x300000 by default.
  - It is read with kind 1 and `wdata` 0, and the read repeats until `rdata` is 0x7C.
  - No write (kind 2, 3 or 4) is requested before that byte is seen.
- R5: If POLL_LIMIT consecutive identity reads all return another value, `err` rises and no further request is made.
- R6: After the identity match, 16-bit writes (kind 3) go to registers 1–5 and then 6–10, in that order.
  - Registers 1–5 receive horizontal cycle, offset, size, sync start and sync end; registers 6–10 receive the vertical equivalents.
  - The default values are 548, 43, 480, 0, 41 and 292, 12, 272, 0, 10.
- R7: Next come two 16-bit writes: 1000 to register 11 (backlight PWM frequency), then the duty to register 12. The duty is 100, or 0 when `bl_invert` is 1.
- R8: Two 8-bit writes (kind 2) of 0x80 follow: first register 13 (GPIO direction), then register 14 (GPIO value).
- R9: Three 32-bit writes (kind 4) follow, in this order:
  - 0x26000007 (clear all) to display-list address DL_BASE (default 0);
  - 0x00000000 (end of list) to DL_BASE+4;
  - 1 to register 15 (list swap).
- R10: After the swap, 16-bit writes go to register 16 (pixel clock divider, default 5) and then register 17 (touch threshold 1200). Then `done` rises.
- R11: `req` stays high with `kind`, `addr` and `wdata` stable until the cycle in which `ack` is high. It is low in the next cycle.
- R12: `done` and `err` are never high together. Once either is high it stays high until reset, and no request follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bl_invert | input | 1 | Backlight polarity strap; 1 selects duty 0 |
| pd_n | output | 1 | Active-low power-down pin of the controller |
| req | output | 1 | Transaction request to the SPI engine |
| kind | output | 3 | 0 host cmd, 1 read 8, 2 write 8, 3 write 16, 4 write 32 |
| addr | output | 22 | Transaction address |
| wdata | output | 32 | Write data, or host code in bits 7:0 |
| ack | input | 1 | One-cycle completion pulse from the engine |
| rdata | input | 8 | Byte returned by a read, valid with `ack` |
| done | output | 1 | Sequence finished |
| err | output | 1 | Identity poll timed out |

## Verification
The bench goes after the ordering hazards:
- a write leaking out before the identity byte is matched;
- a request made while the controller is still powered down;
- a pixel-clock write issued ahead of the list swap.
A design that got these wrong would show a transaction stream that differs from the expected list in order, address or value. It also checks the wait lengths around the power cycle and host commands, where a prescaler or count error shows up as a short or long gap.

The bench drives two polling cases:
- a poll that succeeds after several misses;
- a poll that never succeeds.
A wrong poll budget shows up as one read too many or too few before `err`. The inverted-backlight run catches a duty value that ignores the strap.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   typedef enum logic [2:0] {
      XK_HOST = 3'd0,
      XK_RD8  = 3'd1,
      XK_WR8  = 3'd2,
      XK_WR16 = 3'd3,
      XK_WR32 = 3'd4
   } xfer_kind_e;

   typedef enum logic [2:0] {
      ST_ISSUE = 3'd0,
      ST_BUSY  = 3'd1,
      ST_WAIT  = 3'd2,
      ST_DONE  = 3'd3,
      ST_FAIL  = 3'd4
   } boot_state_e;

   typedef struct packed {
      logic        pin_step;
      logic        pin_level;
      xfer_kind_e  kind;
      logic [21:0] addr;
      logic [31:0] data;
      logic [4:0]  wait_ms;
   } boot_step_t;

   localparam logic [7:0]  HC_WAKE     = 8'h00;
   localparam logic [7:0]  HC_XTAL     = 8'h44;
   localparam logic [7:0]  HC_PLL48    = 8'h62;
   localparam logic [7:0]  HC_CORE_RST = 8'h68;
   localparam logic [7:0]  CHIP_ID     = 8'h7C;
   localparam logic [31:0] DLW_CLEAR   = 32'h2600_0007;
   localparam logic [31:0] DLW_END     = 32'h0000_0000;
   localparam int unsigned N_STEPS     = 26;

endpackage

// File: rtl/dbs_ms_timer.sv
module dbs_ms_timer #(
   parameter int unsigned CLKS_PER_MS = 1000,
   parameter int unsigned MS_W        = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [MS_W-1:0] ms,
   output logic            expire
);
   localparam int unsigned PRE_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;

   logic [MS_W-1:0] left;
   logic            run;
   logic            pre_zero;

   generate
      if (CLKS_PER_MS == 1) begin : g_nopre
         assign pre_zero = 1'b1;
      end else begin : g_pre
         logic [PRE_W-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre <= '0;
            else if (start)
               pre <= PRE_W'(CLKS_PER_MS - 1);
            else if (run)
               pre <= (pre == '0) ? PRE_W'(CLKS_PER_MS - 1) : pre - 1'b1;
         end
         assign pre_zero = (pre == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left <= '0;
         run  <= 1'b0;
      end else if (start) begin
         left <= ms;
         run  <= (ms != '0);
      end else if (run && pre_zero) begin
         left <= left - 1'b1;
         if (left == MS_W'(1)) run <= 1'b0;
      end
   end

   assign expire = run && pre_zero && (left == MS_W'(1));

endmodule

// File: rtl/dbs_step_table.sv
module dbs_step_table
   import dbs_pkg::*;
#(
   parameter int unsigned IDX_W    = 5,
   parameter logic [21:0] REG_BASE = 22'h30_0000,
   parameter logic [21:0] DL_BASE  = 22'h00_0000,
   parameter logic [15:0] H_CYCLE  = 16'd548,
   parameter logic [15:0] H_OFFSET = 16'd43,
   parameter logic [15:0] H_SIZE   = 16'd480,
   parameter logic [15:0] H_SYNC0  = 16'd0,
   parameter logic [15:0] H_SYNC1  = 16'd41,
   parameter logic [15:0] V_CYCLE  = 16'd292,
   parameter logic [15:0] V_OFFSET = 16'd12,
   parameter logic [15:0] V_SIZE   = 16'd272,
   parameter logic [15:0] V_SYNC0  = 16'd0,
   parameter logic [15:0] V_SYNC1  = 16'd10,
   parameter logic [15:0] PWM_FREQ = 16'd1000,
   parameter logic [15:0] PWM_DUTY = 16'd100,
   parameter logic [15:0] PCLK_DIV = 16'd5,
   parameter logic [15:0] TOUCH_RZ = 16'd1200
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             bl_invert,
   output boot_step_t       step
);
   localparam int unsigned TIMING_FIRST = 7;
   localparam int unsigned TIMING_LAST  = 16;
   localparam logic [15:0] TIMING [10] = '{H_CYCLE, H_OFFSET, H_SIZE, H_SYNC0, H_SYNC1,
                                           V_CYCLE, V_OFFSET, V_SIZE, V_SYNC0, V_SYNC1};

   function automatic logic [21:0] reg_at(int unsigned k);
      return REG_BASE + 22'(4 * k);
   endfunction

   function automatic boot_step_t mk(logic pin, logic lvl, xfer_kind_e k,
                                     logic [21:0] a, logic [31:0] d, logic [4:0] w);
      boot_step_t s;
      s.pin_step  = pin;
      s.pin_level = lvl;
      s.kind      = k;
      s.addr      = a;
      s.data      = d;
      s.wait_ms   = w;
      return s;
   endfunction

   logic [3:0] tsel;
   assign tsel = 4'(idx - IDX_W'(TIMING_FIRST));

   always_comb begin
      case (int'(idx))
         0:  step = mk(1'b1, 1'b0, XK_HOST, '0, '0, 5'd20);
         1:  step = mk(1'b1, 1'b1, XK_HOST, '0, '0, 5'd20);
         2:  step = mk(1'b0, 1'b0, XK_HOST, '0, {24'd0, HC_WAKE}, 5'd20);
         3:  step = mk(1'b0, 1'b0, XK_HOST, '0, {24'd0, HC_XTAL}, 5'd10);
         4:  step = mk(1'b0, 1'b0, XK_HOST, '0, {24'd0, HC_PLL48}, 5'd10);
         5:  step = mk(1'b0, 1'b0, XK_HOST, '0, {24'd0, HC_CORE_RST}, 5'd0);
         6:  step = mk(1'b0, 1'b0, XK_RD8, reg_at(0), '0, 5'd0);
         17: step = mk(1'b0, 1'b0, XK_WR16, reg_at(11), {16'd0, PWM_FREQ}, 5'd0);
         18: step = mk(1'b0, 1'b0, XK_WR16, reg_at(12),
                       bl_invert ? 32'd0 : {16'd0, PWM_DUTY}, 5'd0);
         19: step = mk(1'b0, 1'b0, XK_WR8, reg_at(13), 32'h80, 5'd0);
         20: step = mk(1'b0, 1'b0, XK_WR8, reg_at(14), 32'h80, 5'd0);
         21: step = mk(1'b0, 1'b0, XK_WR32, DL_BASE, DLW_CLEAR, 5'd0);
         22: step = mk(1'b0, 1'b0, XK_WR32, DL_BASE + 22'd4, DLW_END, 5'd0);
         23: step = mk(1'b0, 1'b0, XK_WR32, reg_at(15), 32'd1, 5'd0);
         24: step = mk(1'b0, 1'b0, XK_WR16, reg_at(16), {16'd0, PCLK_DIV}, 5'd0);
         25: step = mk(1'b0, 1'b0, XK_WR16, reg_at(17), {16'd0, TOUCH_RZ}, 5'd0);
         default: begin
            if (int'(idx) >= TIMING_FIRST && int'(idx) <= TIMING_LAST)
               step = mk(1'b0, 1'b0, XK_WR16, REG_BASE + 22'({tsel, 2'b00}) + 22'd4,
                         {16'd0, TIMING[tsel]}, 5'd0);
            else
               step = mk(1'b0, 1'b0, XK_HOST, '0, '0, 5'd0);
         end
      endcase
   end

endmodule

// File: rtl/dbs_boot_seq.sv
module dbs_boot_seq
   import dbs_pkg::*;
#(
   parameter int unsigned CLKS_PER_MS = 48000,
   parameter int unsigned POLL_LIMIT  = 1024,
   parameter logic [21:0] REG_BASE    = 22'h30_0000,
   parameter logic [21:0] DL_BASE     = 22'h00_0000,
   parameter logic [15:0] H_CYCLE     = 16'd548,
   parameter logic [15:0] H_OFFSET    = 16'd43,
   parameter logic [15:0] H_SIZE      = 16'd480,
   parameter logic [15:0] H_SYNC0     = 16'd0,
   parameter logic [15:0] H_SYNC1     = 16'd41,
   parameter logic [15:0] V_CYCLE     = 16'd292,
   parameter logic [15:0] V_OFFSET    = 16'd12,
   parameter logic [15:0] V_SIZE      = 16'd272,
   parameter logic [15:0] V_SYNC0     = 16'd0,
   parameter logic [15:0] V_SYNC1     = 16'd10,
   parameter logic [15:0] PWM_FREQ    = 16'd1000,
   parameter logic [15:0] PWM_DUTY    = 16'd100,
   parameter logic [15:0] PCLK_DIV    = 16'd5,
   parameter logic [15:0] TOUCH_RZ    = 16'd1200
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bl_invert,
   output logic        pd_n,
   output logic        req,
   output logic [2:0]  kind,
   output logic [21:0] addr,
   output logic [31:0] wdata,
   input  logic        ack,
   input  logic [7:0]  rdata,
   output logic        done,
   output logic        err
);
   localparam int unsigned IDX_W  = $clog2(N_STEPS);
   localparam int unsigned LAST   = N_STEPS - 1;
   localparam int unsigned POLL_W = $clog2(POLL_LIMIT + 1);

   generate
      if (CLKS_PER_MS < 1) begin : g_bad_clk
         $error("CLKS_PER_MS must be at least 1");
      end
      if (POLL_LIMIT < 1) begin : g_bad_poll
         $error("POLL_LIMIT must be at least 1");
      end
   endgenerate

   boot_state_e       state;
   logic [IDX_W-1:0]  idx;
   logic [POLL_W-1:0] polls;
   boot_step_t        step;
   logic              tmr_start;
   logic              tmr_expire;
   logic              last_step;
   logic              id_miss;

   dbs_step_table #(
      .IDX_W(IDX_W), .REG_BASE(REG_BASE), .DL_BASE(DL_BASE),
      .H_CYCLE(H_CYCLE), .H_OFFSET(H_OFFSET), .H_SIZE(H_SIZE),
      .H_SYNC0(H_SYNC0), .H_SYNC1(H_SYNC1),
      .V_CYCLE(V_CYCLE), .V_OFFSET(V_OFFSET), .V_SIZE(V_SIZE),
      .V_SYNC0(V_SYNC0), .V_SYNC1(V_SYNC1),
      .PWM_FREQ(PWM_FREQ), .PWM_DUTY(PWM_DUTY),
      .PCLK_DIV(PCLK_DIV), .TOUCH_RZ(TOUCH_RZ)
   ) u_table (
      .idx       (idx),
      .bl_invert (bl_invert),
      .step      (step)
   );

   dbs_ms_timer #(
      .CLKS_PER_MS(CLKS_PER_MS), .MS_W(5)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tmr_start),
      .ms     (step.wait_ms),
      .expire (tmr_expire)
   );

   assign last_step = (idx == IDX_W'(LAST));
   assign id_miss   = (step.kind == XK_RD8) && (rdata != CHIP_ID);
   assign tmr_start = ((state == ST_ISSUE) && step.pin_step) ||
                      ((state == ST_BUSY) && ack && !id_miss && (step.wait_ms != '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_ISSUE;
         idx   <= '0;
         polls <= '0;
         pd_n  <= 1'b1;
      end else begin
         case (state)
            ST_ISSUE: begin
               if (step.pin_step) begin
                  pd_n  <= step.pin_level;
                  state <= ST_WAIT;
               end else begin
                  state <= ST_BUSY;
               end
            end
            ST_BUSY: begin
               if (ack) begin
                  if (id_miss) begin
                     if (polls == POLL_W'(POLL_LIMIT - 1)) begin
                        state <= ST_FAIL;
                     end else begin
                        polls <= polls + 1'b1;
                        state <= ST_ISSUE;
                     end
                  end else if (step.wait_ms != '0) begin
                     state <= ST_WAIT;
                  end else if (last_step) begin
                     state <= ST_DONE;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= ST_ISSUE;
                  end
               end
            end
            ST_WAIT: begin
               if (tmr_expire) begin
                  if (last_step) begin
                     state <= ST_DONE;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= ST_ISSUE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign req   = (state == ST_BUSY);
   assign kind  = step.kind;
   assign addr  = step.addr;
   assign wdata = step.data;
   assign done  = (state == ST_DONE);
   assign err   = (state == ST_FAIL);

endmodule

// File: rtl/dbs_boot_checker.sv
module dbs_boot_checker
   import dbs_pkg::*;
#(
   parameter int unsigned POLL_LIMIT = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        pd_n,
   input logic        req,
   input logic [2:0]  kind,
   input logic [21:0] addr,
   input logic [31:0] wdata,
   input logic        ack,
   input logic [7:0]  rdata,
   input logic        done,
   input logic        err
);
   localparam int unsigned CW = $clog2(POLL_LIMIT + 2);

   logic          id_seen;
   logic [CW-1:0] misses;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_seen <= 1'b0;
         misses  <= '0;
      end else if (req && ack && (kind == XK_RD8)) begin
         if (rdata == CHIP_ID) id_seen <= 1'b1;
         else                  misses  <= misses + 1'b1;
      end
   end

   assert_hold_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> (req && $stable(kind) && $stable(addr) && $stable(wdata)));

   assert_drop_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ack) |=> !req);

   assert_quiet_in_powerdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |-> !req);

   assert_no_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && (kind >= 3'd2)) |-> id_seen);

   assert_poll_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (misses == CW'(POLL_LIMIT)) && !id_seen);

   assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && !err && !req));

   assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> (err && !done && !req));

   assert_done_needs_id_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> id_seen);

endmodule

bind dbs_boot_seq dbs_boot_checker #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .pd_n  (pd_n),
   .req   (req),
   .kind  (kind),
   .addr  (addr),
   .wdata (wdata),
   .ack   (ack),
   .rdata (rdata),
   .done  (done),
   .err   (err)
);

// File: tb/sim_dbs_boot_seq.sv
module sim_dbs_boot_seq;
   localparam int K   = 4;
   localparam int PL  = 6;
   localparam int LAT = 2;
   localparam logic [21:0] RB = 22'h30_0000;
   localparam logic [21:0] DB = 22'h00_0000;

   typedef struct {
      int          kind;
      logic [21:0] addr;
      logic [31:0] data;
      string       tag;
   } txn_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bl_invert = 1'b0;
   logic        pd_n, req, done, err;
   logic [2:0]  kind;
   logic [21:0] addr;
   logic [31:0] wdata;
   logic        ack = 1'b0;
   logic [7:0]  rdata = 8'h00;

   always #4 clk = ~clk;

   dbs_boot_seq #(.CLKS_PER_MS(K), .POLL_LIMIT(PL)) u0 (
      .clk(clk), .rst_n(rst_n), .bl_invert(bl_invert), .pd_n(pd_n),
      .req(req), .kind(kind), .addr(addr), .wdata(wdata),
      .ack(ack), .rdata(rdata), .done(done), .err(err)
   );

   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   txn_t got[$];
   txn_t expq[$];
   int   ack_t[$];
   int   rise_t[$];
   int   t_fall = -1;
   int   t_rise = -1;
   int   bad_reads = 0;
   int   nreads = 0;
   bit   id_ok = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string rq, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
      end
   endtask

   // per-clock model of the SPI engine plus protocol monitor
   initial begin : engine
      bit          p_req = 0;
      bit          p_ack = 0;
      bit          pd_prev = 1;
      logic [2:0]  p_kind = '0;
      logic [21:0] p_addr = '0;
      logic [31:0] p_wdata = '0;
      int          lat = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            check(!(!pd_n && req), "R2", "request while powered down", req, 0);
            if (p_req && !p_ack)
               check(req && kind == p_kind && addr == p_addr && wdata == p_wdata,
                     "R11", "request dropped or changed before ack", {kind, addr}, {p_kind, p_addr});
            if (req && kind >= 3'd2 && !id_ok)
               check(0, "R4", "write before identity match", kind, 1);
            if (pd_prev && !pd_n) t_fall = cyc;
            if (!pd_prev && pd_n) t_rise = cyc;
            if (req && !p_req) rise_t.push_back(cyc);
         end
         p_req = req; p_kind = kind; p_addr = addr; p_wdata = wdata; pd_prev = pd_n;
         if (ack) begin
            ack = 1'b0;
            lat = 0;
         end else if (req && rst_n) begin
            lat++;
            if (lat == LAT) begin
               txn_t t;
               lat = 0;
               t.kind = int'(kind); t.addr = addr; t.data = wdata; t.tag = "";
               got.push_back(t);
               ack_t.push_back(cyc);
               if (kind == 3'd1) begin
                  rdata = (nreads < bad_reads) ? 8'h3C : 8'h7C;
                  if (rdata == 8'h7C) id_ok = 1;
                  nreads++;
               end
               ack = 1'b1;
            end
         end
         p_ack = ack;
      end
   end

   function automatic void add(int k, logic [21:0] a, logic [31:0] d, string tg);
      txn_t t;
      t.kind = k; t.addr = a; t.data = d; t.tag = tg;
      expq.push_back(t);
   endfunction

   function automatic void build(int bad, bit inv, bit fail);
      int tv[10] = '{548, 43, 480, 0, 41, 292, 12, 272, 0, 10};
      expq.delete();
      add(0, 0, 32'h00, "R3");
      add(0, 0, 32'h44, "R3");
      add(0, 0, 32'h62, "R3");
      add(0, 0, 32'h68, "R3");
      if (fail) begin
         for (int i = 0; i < PL; i++) add(1, RB, 0, "R5");
         return;
      end
      for (int i = 0; i <= bad; i++) add(1, RB, 0, "R4");
      for (int i = 0; i < 10; i++) add(3, RB + 22'(4 * (i + 1)), tv[i], "R6");
      add(3, RB + 22'd44, 1000, "R7");
      add(3, RB + 22'd48, inv ? 0 : 100, "R7");
      add(2, RB + 22'd52, 32'h80, "R8");
      add(2, RB + 22'd56, 32'h80, "R8");
      add(4, DB, 32'h2600_0007, "R9");
      add(4, DB + 22'd4, 32'h0, "R9");
      add(4, RB + 22'd60, 32'd1, "R9");
      add(3, RB + 22'd64, 5, "R10");
      add(3, RB + 22'd68, 1200, "R10");
   endfunction

   task automatic in_window(int delta, int ms, string rq, string what);
      check(delta >= ms * K && delta <= ms * K + 2, rq, what, delta, ms * K);
   endtask

   task automatic run(int bad, bit inv, bit fail);
      int n = 0;
      int waits[3] = '{20, 10, 10};
      rst_n = 1'b0;
      bl_invert = inv;
      repeat (3) @(negedge clk);
      check(pd_n == 1'b1, "R1", "pd_n in reset", pd_n, 1);
      check(req == 1'b0 && done == 1'b0 && err == 1'b0, "R1", "req/done/err in reset",
            {req, done, err}, 0);
      got.delete(); ack_t.delete(); rise_t.delete();
      t_fall = -1; t_rise = -1; nreads = 0; id_ok = 0; bad_reads = bad;
      build(bad, inv, fail);
      rst_n = 1'b1;
      while (!(done || err) && n < 5000) begin
         @(negedge clk);
         n++;
      end
      check(n < 5000, "R12", "sequence end reached", n, 5000);
      repeat (12) @(negedge clk);
      if (fail)
         check(err == 1'b1 && done == 1'b0, "R5", "err after poll budget", {done, err}, 2'b01);
      else
         check(done == 1'b1 && err == 1'b0, "R10", "done at end", {done, err}, 2'b10);
      check(req == 1'b0, "R12", "no request after end", req, 0);
      check(got.size() == expq.size(), "R12", "transaction count", got.size(), expq.size());
      for (int i = 0; i < expq.size() && i < got.size(); i++) begin
         check(got[i].kind == expq[i].kind, expq[i].tag, $sformatf("kind of txn %0d", i),
               got[i].kind, expq[i].kind);
         check(got[i].addr == expq[i].addr, expq[i].tag, $sformatf("addr of txn %0d", i),
               got[i].addr, expq[i].addr);
         check(got[i].data == expq[i].data, expq[i].tag, $sformatf("data of txn %0d", i),
               got[i].data, expq[i].data);
      end
      check(pd_n == 1'b1, "R2", "pd_n high after power cycle", pd_n, 1);
      check(t_fall >= 0 && t_rise > t_fall, "R2", "power-down pulse seen", t_rise, t_fall);
      in_window(t_rise - t_fall, 20, "R2", "power-down low time");
      if (rise_t.size() > 0) in_window(rise_t[0] - t_rise, 20, "R2", "pause after power-up");
      for (int i = 0; i < 3; i++)
         if (rise_t.size() > i + 1 && ack_t.size() > i)
            in_window(rise_t[i + 1] - ack_t[i], waits[i], "R3", $sformatf("wait after host cmd %0d", i));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      run(3, 1'b0, 1'b0);
      run(1000, 1'b1, 1'b1);
      run(0, 1'b1, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule